// File: doc/BRIEF.md
# Sampled Rotary Encoder Detent Decoder

This block turns an externally debounced two-phase rotary encoder into step events on an 8-bit coarse delay setting. The encoder is not watched continuously: a divider counts audio frame strobes and takes one look at the encoder every 64 frames. That gives a sampling interval of about 1.5 ms at common audio rates. This slow sampling rejects residual chatter without a full quadrature state machine.

On each look the decoder checks phase A. A high level re-arms the edge detector. The first low level after re-arming counts as one detent. Phase B, read at that same look, gives the direction: low turns the setting up, high turns it down. The setting is a byte that wraps in both directions. It is also presented pre-scaled as an address offset, where one step equals 256 address units, for a delay-line pointer. A one-cycle event pulse with a direction bit accompanies every change.

Top module: `rotary_detent_decoder`

## Requirements
- R1: After a synchronous reset the setting equals INIT_DELAY (default 0), the address offset is 0 and the event pulse is low.
- R2: The encoder is examined only on the frame strobe that brings the frame count to its end. This is the 64th strobe after reset and every 64th strobe after that. No other strobe can change the setting.
- R3: An examination that finds phase A high re-arms the detector and leaves the setting unchanged.
- R4: An examination that finds phase A low while the detector is already disarmed changes nothing.
- R5: An examination that finds phase A low while armed, with phase B low, disarms the detector and raises the setting by one. In the cycle after that examination, the event pulse is high and the direction bit is 1.
- R6: The same case with phase B high lowers the setting by one, with the direction bit 0.
- R7: The setting wraps modulo 256: 255 plus one gives 0, and 0 minus one gives 255.
- R8: The address offset output always equals the setting multiplied by 256.
- R9: Encoder activity between examinations has no effect, and the setting holds in every cycle without an examination.
- R10: Each phase input passes through two flip-flops before it is used, so a level reaches an examination only after two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_tick | input | 1 | One-cycle pulse per audio frame |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| delay_hi | output | 8 | Coarse delay setting |
| delay_units | output | 16 | Setting scaled to address units (setting x 256) |
| step_valid | output | 1 | One-cycle pulse when the setting changed |
| step_up | output | 1 | Direction of the last change: 1 up, 0 down |

## Verification
A wrong frame count would move a step to the wrong strobe. That shows up within one 64-frame window as a setting that changes one strobe early or late. A stuck or inverted armed flag would either repeat steps while phase A stays low or lose the step after a re-arm. Either fault appears in the setting at the second examination. A wrong synchroniser depth would show only when phase A changes within two cycles of an examination, so the bench places such edges on purpose. A fault in the wrap or the scaling shows at the first step across 0 or 255.

// File: rtl/detent_pkg.sv
package detent_pkg;

  typedef enum logic {
    TURN_DOWN = 1'b0,
    TURN_UP   = 1'b1
  } turn_dir_e;

  typedef struct packed {
    logic ph_a;
    logic ph_b;
  } phase_pair_t;

endpackage

// File: rtl/phase_sync.sv
module phase_sync #(
  parameter int WIDTH     = 2,
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[s] <= {WIDTH{RESET_VAL}};
          else     chain_q[s] <= async_in;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) chain_q[s] <= {WIDTH{RESET_VAL}};
          else     chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/frame_divider.sv
module frame_divider #(
  parameter int DIV = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_tick,
  output logic sample_tick
);

  localparam int CW = $clog2(DIV + 1);
  localparam logic [CW-1:0] RELOAD = CW'(DIV);
  localparam logic [CW-1:0] LAST   = CW'(1);

  logic [CW-1:0] remain_q;

  assign sample_tick = frame_tick && (remain_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      remain_q <= RELOAD;
    end else if (frame_tick) begin
      if (remain_q == LAST) remain_q <= RELOAD;
      else                  remain_q <= remain_q - LAST;
    end
  end

endmodule

// File: rtl/edge_arm_decoder.sv
module edge_arm_decoder
  import detent_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        sample_tick,
  input  phase_pair_t phases,
  output logic        step_req,
  output turn_dir_e   step_dir
);

  logic armed_q;

  // A detent counts only on the first low look at phase A after a high look.
  assign step_req = sample_tick && !phases.ph_a && armed_q;
  assign step_dir = phases.ph_b ? TURN_DOWN : TURN_UP;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b1;
    end else if (sample_tick) begin
      if (phases.ph_a) armed_q <= 1'b1;
      else             armed_q <= 1'b0;
    end
  end

endmodule

// File: rtl/delay_accum.sv
module delay_accum
  import detent_pkg::*;
#(
  parameter int          DELAY_W    = 8,
  parameter logic [DELAY_W-1:0] INIT_DELAY = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               step_req,
  input  turn_dir_e          step_dir,
  output logic [DELAY_W-1:0] delay_q,
  output logic               valid_q,
  output logic               up_q
);

  localparam logic [DELAY_W-1:0] ONE = DELAY_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      delay_q <= INIT_DELAY;
      valid_q <= 1'b0;
      up_q    <= 1'b0;
    end else begin
      valid_q <= step_req;
      if (step_req) begin
        up_q <= (step_dir == TURN_UP);
        if (step_dir == TURN_UP) delay_q <= delay_q + ONE;
        else                     delay_q <= delay_q - ONE;
      end
    end
  end

endmodule

// File: rtl/rotary_detent_decoder.sv
module rotary_detent_decoder
  import detent_pkg::*;
#(
  parameter int DELAY_W     = 8,
  parameter int STEP_SHIFT  = 8,
  parameter int FRAME_DIV   = 64,
  parameter int SYNC_STAGES = 2,
  parameter logic [DELAY_W-1:0] INIT_DELAY = '0
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          frame_tick,
  input  logic                          enc_a,
  input  logic                          enc_b,
  output logic [DELAY_W-1:0]            delay_hi,
  output logic [DELAY_W+STEP_SHIFT-1:0] delay_units,
  output logic                          step_valid,
  output logic                          step_up
);

  logic        sample_tick;
  logic [1:0]  raw_ph;
  logic [1:0]  sync_ph;
  phase_pair_t phases;
  logic        step_req;
  turn_dir_e   step_dir;

  assign raw_ph      = {enc_a, enc_b};
  assign phases.ph_a = sync_ph[1];
  assign phases.ph_b = sync_ph[0];

  phase_sync #(
    .WIDTH     (2),
    .STAGES    (SYNC_STAGES),
    .RESET_VAL (1'b1)
  ) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (raw_ph),
    .sync_out (sync_ph)
  );

  frame_divider #(
    .DIV (FRAME_DIV)
  ) u_div (
    .clk         (clk),
    .rst         (rst),
    .frame_tick  (frame_tick),
    .sample_tick (sample_tick)
  );

  edge_arm_decoder u_dec (
    .clk         (clk),
    .rst         (rst),
    .sample_tick (sample_tick),
    .phases      (phases),
    .step_req    (step_req),
    .step_dir    (step_dir)
  );

  delay_accum #(
    .DELAY_W    (DELAY_W),
    .INIT_DELAY (INIT_DELAY)
  ) u_acc (
    .clk      (clk),
    .rst      (rst),
    .step_req (step_req),
    .step_dir (step_dir),
    .delay_q  (delay_hi),
    .valid_q  (step_valid),
    .up_q     (step_up)
  );

  assign delay_units = {delay_hi, {STEP_SHIFT{1'b0}}};

endmodule

// File: rtl/detent_checker.sv
module detent_checker #(
  parameter int DELAY_W    = 8,
  parameter int STEP_SHIFT = 8
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          frame_tick,
  input logic [DELAY_W-1:0]            delay_hi,
  input logic [DELAY_W+STEP_SHIFT-1:0] delay_units,
  input logic                          step_valid,
  input logic                          step_up
);

  localparam logic [DELAY_W-1:0] ONE  = DELAY_W'(1);
  localparam logic [DELAY_W-1:0] MONE = {DELAY_W{1'b1}};

  // R9: without a strobe in the previous cycle the setting cannot move
  p_hold_no_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    !frame_tick |=> $stable(delay_hi));

  // R4: no event pulse means the setting did not change
  p_hold_no_event_r4: assert property (@(posedge clk) disable iff (rst)
    !step_valid |-> $stable(delay_hi));

  // R5 / R7: an up event moves the setting by exactly +1 modulo 256
  p_step_up_r5: assert property (@(posedge clk) disable iff (rst)
    (step_valid && step_up) |-> (DELAY_W'(delay_hi - $past(delay_hi)) == ONE));

  // R6 / R7: a down event moves the setting by exactly -1 modulo 256
  p_step_down_r6: assert property (@(posedge clk) disable iff (rst)
    (step_valid && !step_up) |-> (DELAY_W'(delay_hi - $past(delay_hi)) == MONE));

  // R2: an event always follows a strobe and never repeats on the next cycle
  p_event_after_strobe_r2: assert property (@(posedge clk) disable iff (rst)
    step_valid |-> $past(frame_tick));

  p_event_single_r2: assert property (@(posedge clk) disable iff (rst)
    step_valid |=> !step_valid);

endmodule

bind rotary_detent_decoder detent_checker #(
  .DELAY_W    (DELAY_W),
  .STEP_SHIFT (STEP_SHIFT)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .frame_tick  (frame_tick),
  .delay_hi    (delay_hi),
  .delay_units (delay_units),
  .step_valid  (step_valid),
  .step_up     (step_up)
);

// File: tb/sim_rotary_detent_decoder.sv
`timescale 1ns/1ps
module sim_rotary_detent_decoder;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_tick = 1'b0;
  logic        enc_a = 1'b1;
  logic        enc_b = 1'b1;
  logic [7:0]  delay_hi;
  logic [15:0] delay_units;
  logic        step_valid;
  logic        step_up;

  int n_checks = 0;
  int n_fail   = 0;
  bit model_on = 1'b0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  rotary_detent_decoder u0 (
    .clk         (clk),
    .rst         (rst),
    .frame_tick  (frame_tick),
    .enc_a       (enc_a),
    .enc_b       (enc_b),
    .delay_hi    (delay_hi),
    .delay_units (delay_units),
    .step_valid  (step_valid),
    .step_up     (step_up)
  );

  // Behavioural reference model, advanced at every rising edge
  int m_cnt, m_dly;
  bit m_arm, m_sv, m_up;
  bit m_a1, m_a2, m_b1, m_b2;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 64; m_dly = 0; m_arm = 1; m_sv = 0; m_up = 0;
      m_a1 = 1; m_a2 = 1; m_b1 = 1; m_b2 = 1;
    end else begin
      m_sv = 0;
      if (frame_tick) begin
        if (m_cnt == 1) begin
          m_cnt = 64;
          if (m_a2) m_arm = 1;
          else if (m_arm) begin
            m_arm = 0;
            m_sv  = 1;
            m_up  = !m_b2;
            m_dly = m_up ? (m_dly + 1) % 256 : (m_dly + 255) % 256;
          end else m_arm = 0;
        end else m_cnt = m_cnt - 1;
      end
      m_a2 = m_a1; m_a1 = enc_a;
      m_b2 = m_b1; m_b1 = enc_b;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (model_on && !rst) begin
      check(m_sv ? (m_up ? "R5 model event" : "R6 model event") : "R9 model hold",
            delay_hi, m_dly);
      check("R2 model pulse", step_valid, m_sv);
      if (m_sv) check("R5/R6 model dir", step_up, m_up);
      check("R8 model offset", delay_units, m_dly * 256);
    end
  end

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) frame_tick = 1'b1;
      @(negedge clk) frame_tick = 1'b0;
    end
  endtask

  task automatic look(input bit a, input bit b);
    @(negedge clk); enc_a = a; enc_b = b;
    repeat (4) @(negedge clk);
    ticks(64);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset setting", delay_hi, 0);
    check("R1 reset offset", delay_units, 0);
    check("R1 reset pulse", step_valid, 0);
    model_on = 1'b1;

    enc_a = 1'b0; enc_b = 1'b0;
    repeat (4) @(negedge clk);
    ticks(63);
    check("R2 before 64th strobe", delay_hi, 0);
    ticks(1);
    check("R5 up step", delay_hi, 1);
    check("R5 direction", step_up, 1);

    ticks(64);
    check("R4 disarmed low ignored", delay_hi, 1);

    look(1'b1, 1'b1);
    check("R3 high rearms only", delay_hi, 1);
    look(1'b0, 1'b1);
    check("R6 down step", delay_hi, 0);
    check("R6 direction", step_up, 0);
    look(1'b1, 1'b1);
    look(1'b0, 1'b1);
    check("R7 wrap below zero", delay_hi, 255);
    check("R8 offset at 255", delay_units, 16'hFF00);
    look(1'b1, 1'b0);
    look(1'b0, 1'b0);
    check("R7 wrap above 255", delay_hi, 0);

    // R9: phase A pulses high between looks but is low at the look
    enc_a = 1'b1; ticks(10);
    enc_a = 1'b0; ticks(54);
    check("R9 activity between looks", delay_hi, 0);

    // R10: A goes high so the next look re-arms
    look(1'b1, 1'b0);
    // A falls right at the 64th strobe; synchroniser hides it
    ticks(63);
    @(negedge clk) begin enc_a = 1'b0; frame_tick = 1'b1; end
    @(negedge clk) frame_tick = 1'b0;
    check("R10 late edge not seen", delay_hi, 0);
    ticks(64);
    check("R10 edge seen next look", delay_hi, 1);

    // Mixed stimulus against the model
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      frame_tick = ($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 40) == 0) enc_a = ~enc_a;
      if ($urandom_range(0, 30) == 0) enc_b = ~enc_b;
    end
    frame_tick = 1'b0;
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    check("R1 reset after activity", delay_hi, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule